// File: doc/BRIEF.md
# Hblank-Safe Pattern Bank Switcher

This block holds the bank numbers that steer the pattern-memory address path of a tile-based video generator. It keeps four background windows and four sprite windows. It also runs the dot and scanline counters from the dot clock. The CPU side programs a window with two writes: the first names a slot, and the second supplies the bank number.

While the display is being drawn, a bank number does not reach the outputs when it is written. It waits in a small pending queue. Background entries are released on the edge where the dot count moves from 248 to 249. At that point the last visible background fetch is done and the sprite fetch span has not yet begun. Sprite entries are released on the edge into dot 321, when the sprite fetches for the next line have finished. As a result, a mid-frame bank change cannot tear a tile.

During vertical blank, or while rendering is off, writes go straight through. The block pulses a flag when a background write arrives after the next line's prefetch has started. It pulses a second flag when the queue has no room for a new slot.

Top module: `pattern_bank_sched`

## Requirements
- R1: The dot counter runs 0 to 340 and then returns to 0. The scanline counter advances on each dot wrap, runs 0 to 261 and then returns to 0.
- R2: A write with `cpu_addr`=0 latches the slot number from `cpu_wdata[2:0]`. A write with `cpu_addr`=1 stores `cpu_wdata` as the bank for the latched slot. Slots 0-3 are background windows 0-3 and slots 4-7 are sprite windows 0-3. Window i appears on bits [8i+7:8i] of `bg_bank` or `spr_bank`.
- R3: While active (`rendering`=1 and scanline < 240), pending background entries are applied together on the edge where dot goes from 248 to 249. The new value is first visible while dot is 249, and the old value is still present at dot 248.
- R4: While active, pending sprite entries are applied together on the edge where dot goes from 320 to 321.
- R5: A data write presented on a commit edge is held until the following window of its kind. A second write to a slot that is already pending replaces the earlier value.
- R6: The queue holds up to four distinct slots. A data write to a fifth distinct slot makes `overflow` high for exactly one cycle, and that write is discarded. Overwriting a slot that is already pending does not raise `overflow`.
- R7: While not active, a data write updates its window on the edge that takes it, and every pending entry is applied on the first idle edge.
- R8: `late` is high for one cycle after an active-time background data write taken while dot is in 321..340. That write still takes effect at the next dot-249 commit. Idle-time writes never raise `late`.
- R9: With `bg_wide`=1, background slot s in {0,1} with value v sets window 2s to {v[7:1],0} and window 2s+1 to {v[7:1],1}. Background slots 2 and 3 then have no effect.
- R10: After reset, dot, scanline, every bank, `late` and `overflow` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rendering | input | 1 | Rendering enabled |
| bg_wide | input | 1 | Background mapped as two double-size windows |
| cpu_we | input | 1 | CPU write strobe, one dot per write |
| cpu_addr | input | 1 | 0 = slot select, 1 = bank data |
| cpu_wdata | input | 8 | Write data |
| dot | output | 9 | Current dot within the scanline |
| line | output | 9 | Current scanline |
| bg_bank | output | 32 | Four background window bank numbers |
| spr_bank | output | 32 | Four sprite window bank numbers |
| late | output | 1 | One-cycle pulse: background write arrived after prefetch start |
| overflow | output | 1 | One-cycle pulse: pending queue full, write discarded |

## Verification
The hardest cases to reach from the ports are a write that lands exactly on a commit edge, and a fifth distinct slot arriving while four entries are still waiting. Both depend on the exact dot at which a two-write sequence completes. The stimulus therefore places each data write at an absolute dot count measured from the end of reset, for example dot 248 and dots 10 to 19 of one line. Each expected bank vector is then checked on both sides of the commit edge. Switching rendering off while an entry is pending confirms that pending entries are applied on the first idle edge.

// File: rtl/pattern_bank_sched.sv
module pattern_bank_sched #(
  parameter int DOTS       = 341,
  parameter int LINES      = 262,
  parameter int VIS_LINES  = 240,
  parameter int BG_COMMIT  = 249,
  parameter int SPR_COMMIT = 321,
  parameter int BANK_W     = 8,
  parameter int WIN        = 4,
  parameter int QDEPTH     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rendering,
  input  logic                        bg_wide,
  input  logic                        cpu_we,
  input  logic                        cpu_addr,
  input  logic [BANK_W-1:0]           cpu_wdata,
  output logic [$clog2(DOTS)-1:0]     dot,
  output logic [$clog2(LINES)-1:0]    line,
  output logic [WIN*BANK_W-1:0]       bg_bank,
  output logic [WIN*BANK_W-1:0]       spr_bank,
  output logic                        late,
  output logic                        overflow
);
  localparam int DOT_W  = $clog2(DOTS);
  localparam int LINE_W = $clog2(LINES);
  localparam int WIN_W  = $clog2(WIN);
  localparam int SLOT_W = WIN_W + 1;
  localparam logic [DOT_W-1:0]  DOT_LAST  = DOT_W'(DOTS - 1);
  localparam logic [DOT_W-1:0]  BG_EDGE   = DOT_W'(BG_COMMIT - 1);
  localparam logic [DOT_W-1:0]  SPR_EDGE  = DOT_W'(SPR_COMMIT - 1);
  localparam logic [DOT_W-1:0]  LATE_LO   = DOT_W'(SPR_COMMIT);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);
  localparam logic [LINE_W-1:0] VIS_END   = LINE_W'(VIS_LINES);

  logic [SLOT_W-1:0] sel_q;
  logic [QDEPTH-1:0] q_v;
  logic [SLOT_W-1:0] q_slot [QDEPTH];
  logic [BANK_W-1:0] q_val  [QDEPTH];
  logic [BANK_W-1:0] bg_q  [WIN], bg_n  [WIN];
  logic [BANK_W-1:0] spr_q [WIN], spr_n [WIN];

  logic active, bg_edge, spr_edge, dwr, stage;
  assign active   = rendering && (line < VIS_END);
  assign bg_edge  = active && (dot == BG_EDGE);
  assign spr_edge = active && (dot == SPR_EDGE);
  assign dwr      = cpu_we && cpu_addr;
  assign stage    = dwr && active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dot  <= '0;
      line <= '0;
    end else if (dot == DOT_LAST) begin
      dot  <= '0;
      line <= (line == LINE_LAST) ? '0 : line + 1'b1;
    end else begin
      dot <= dot + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else if (cpu_we && !cpu_addr) sel_q <= cpu_wdata[SLOT_W-1:0];
  end

  logic [QDEPTH-1:0] flush, keep, hit, alloc;
  logic [QDEPTH:0]   ap_en;
  logic [SLOT_W-1:0] ap_slot [QDEPTH+1];
  logic [BANK_W-1:0] ap_val  [QDEPTH+1];

  for (genvar i = 0; i < QDEPTH; i++) begin : g_entry
    assign flush[i]   = q_v[i] && (!active ||
                        (bg_edge && !q_slot[i][SLOT_W-1]) ||
                        (spr_edge && q_slot[i][SLOT_W-1]));
    assign keep[i]    = q_v[i] && !flush[i];
    assign hit[i]     = keep[i] && (q_slot[i] == sel_q);
    assign ap_en[i]   = flush[i];
    assign ap_slot[i] = q_slot[i];
    assign ap_val[i]  = q_val[i];
  end
  assign ap_en[QDEPTH]   = dwr && !active;
  assign ap_slot[QDEPTH] = sel_q;
  assign ap_val[QDEPTH]  = cpu_wdata;

  logic taken;
  always_comb begin
    alloc = '0;
    taken = 1'b0;
    for (int i = 0; i < QDEPTH; i++) begin
      if (stage && !(|hit) && !keep[i] && !taken) begin
        alloc[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_v <= '0;
      for (int i = 0; i < QDEPTH; i++) begin
        q_slot[i] <= '0;
        q_val[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < QDEPTH; i++) begin
        if (alloc[i]) begin
          q_v[i]    <= 1'b1;
          q_slot[i] <= sel_q;
          q_val[i]  <= cpu_wdata;
        end else if (stage && hit[i]) begin
          q_val[i] <= cpu_wdata;
        end else if (flush[i]) begin
          q_v[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    bg_n  = bg_q;
    spr_n = spr_q;
    for (int i = 0; i <= QDEPTH; i++) begin
      if (ap_en[i]) begin
        if (ap_slot[i][SLOT_W-1]) begin
          spr_n[ap_slot[i][WIN_W-1:0]] = ap_val[i];
        end else if (!bg_wide) begin
          bg_n[ap_slot[i][WIN_W-1:0]] = ap_val[i];
        end else if (!ap_slot[i][WIN_W-1]) begin
          bg_n[{ap_slot[i][WIN_W-2:0], 1'b0}] = {ap_val[i][BANK_W-1:1], 1'b0};
          bg_n[{ap_slot[i][WIN_W-2:0], 1'b1}] = {ap_val[i][BANK_W-1:1], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) begin
        bg_q[i]  <= '0;
        spr_q[i] <= '0;
      end
      late     <= 1'b0;
      overflow <= 1'b0;
    end else begin
      bg_q     <= bg_n;
      spr_q    <= spr_n;
      late     <= stage && !sel_q[SLOT_W-1] && (dot >= LATE_LO);
      overflow <= stage && !(|hit) && !taken;
    end
  end

  for (genvar g = 0; g < WIN; g++) begin : g_out
    assign bg_bank[g*BANK_W +: BANK_W]  = bg_q[g];
    assign spr_bank[g*BANK_W +: BANK_W] = spr_q[g];
  end

  assert_dot_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dot == DOT_LAST |=> dot == '0);

  assert_bg_commit_point_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bg_bank) |-> ($past(dot) == BG_EDGE || !$past(active)));

  assert_spr_commit_point_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spr_bank) |-> ($past(dot) == SPR_EDGE || !$past(active)));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(&q_v));

  assert_idle_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> q_v == '0);

  assert_late_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    late |-> $past(cpu_we && cpu_addr && dot >= LATE_LO && active));
endmodule

// File: tb/test_pattern_bank_sched.sv
`timescale 1ns/1ps
module test_pattern_bank_sched;
  localparam int K_BG = 0, K_SPR = 1, K_LATE = 2, K_OVF = 3, K_DOT = 4, K_LINE = 5;

  logic clk = 1'b0, rst_n = 1'b0, rendering = 1'b1, bg_wide = 1'b0;
  logic cpu_we = 1'b0, cpu_addr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [8:0]  dot, line;
  logic [31:0] bg_bank, spr_bank;
  logic late, overflow;

  pattern_bank_sched i_pattern_bank_sched (
    .clk(clk), .rst_n(rst_n), .rendering(rendering), .bg_wide(bg_wide),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .dot(dot), .line(line), .bg_bank(bg_bank), .spr_bank(spr_bank),
    .late(late), .overflow(overflow));

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  typedef struct {
    int          at;
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb[$];
  item_t mon_it;
  int n_chk = 0, n_fail = 0;
  logic [31:0] got;

  function automatic logic [31:0] pk(int a, int b, int c, int d);
    return {d[7:0], c[7:0], b[7:0], a[7:0]};
  endfunction

  function automatic logic [31:0] observe(int kind);
    case (kind)
      K_BG:    return bg_bank;
      K_SPR:   return spr_bank;
      K_LATE:  return {31'b0, late};
      K_OVF:   return {31'b0, overflow};
      K_DOT:   return {23'b0, dot};
      default: return {23'b0, line};
    endcase
  endfunction

  task automatic push(int at, int kind, logic [31:0] exp, string req);
    item_t it;
    int pos;
    it = '{at, kind, exp, req};
    pos = 0;
    while (pos < sb.size() && sb[pos].at <= at) pos++;
    sb.insert(pos, it);
  endtask

  always @(negedge clk) begin
    #1;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      mon_it = sb.pop_front();
      got = observe(mon_it.kind);
      n_chk++;
      if (mon_it.at != cyc || got !== mon_it.exp) begin
        n_fail++;
        $display("FAIL %s cycle %0d kind %0d: actual %h expected %h",
                 mon_it.req, mon_it.at, mon_it.kind, got, mon_it.exp);
      end
    end
  end

  task automatic wait_cyc(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic bw(int c, int slot, int val);
    wait_cyc(c - 1);
    cpu_we = 1'b1; cpu_addr = 1'b0; cpu_wdata = 8'(slot);
    @(negedge clk);
    cpu_addr = 1'b1; cpu_wdata = 8'(val);
    @(negedge clk);
    cpu_we = 1'b0; cpu_addr = 1'b0;
  endtask

  task automatic finish_run();
    if (sb.size() > 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: actual %0d items left expected 0", sb.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R10 reset state
    push(0, K_BG, 0, "R10"); push(0, K_SPR, 0, "R10");
    push(0, K_LATE, 0, "R10"); push(0, K_OVF, 0, "R10");
    push(0, K_DOT, 0, "R10"); push(0, K_LINE, 0, "R10");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 first dot wrap
    push(340, K_DOT, 340, "R1"); push(341, K_DOT, 0, "R1"); push(341, K_LINE, 1, "R1");

    // R2 R3 R4 basic staging
    push(248, K_BG, 0, "R3");
    push(249, K_BG, pk(0, 8'h12, 0, 0), "R3");
    push(320, K_SPR, 0, "R4");
    push(321, K_SPR, pk(0, 8'h34, 0, 0), "R4");
    bw(11, 1, 8'h12);
    bw(13, 5, 8'h34);

    // R5 overwrite and write on commit edge
    push(589, K_BG, pk(0, 8'h12, 0, 0), "R5");
    push(590, K_BG, pk(8'h21, 8'h12, 0, 0), "R5");
    push(590, K_LATE, 0, "R8");
    push(931, K_BG, pk(8'h21, 8'h12, 8'h55, 0), "R5");
    bw(351, 0, 8'h20);
    bw(353, 0, 8'h21);
    bw(589, 2, 8'h55);

    // R8 late background write
    push(1013, K_LATE, 1, "R8");
    push(1014, K_LATE, 0, "R8");
    push(1271, K_BG, pk(8'h21, 8'h12, 8'h55, 0), "R8");
    push(1272, K_BG, pk(8'h21, 8'h12, 8'h55, 8'h66), "R8");
    bw(1012, 3, 8'h66);

    // R6 queue full
    push(1383, K_OVF, 1, "R6");
    push(1384, K_OVF, 0, "R6");
    push(1385, K_OVF, 0, "R6");
    push(1613, K_BG, pk(5, 2, 3, 8'h44), "R6");
    push(1685, K_SPR, pk(0, 8'h34, 0, 0), "R6");
    bw(1374, 0, 1);
    bw(1376, 1, 2);
    bw(1378, 2, 3);
    bw(1380, 3, 8'h44);
    bw(1382, 4, 8'hEE);
    bw(1384, 0, 5);

    // R9 wide background windows
    wait_cyc(1710);
    bg_wide = 1'b1;
    push(1954, K_BG, pk(8'h80, 8'h81, 3, 8'h44), "R9");
    bw(1715, 0, 8'h81);
    bw(1717, 3, 8'h99);
    wait_cyc(1960);
    bg_wide = 1'b0;

    // R4 R5 sprite write on its commit edge
    push(2026, K_SPR, pk(0, 8'h34, 0, 0), "R4");
    push(2367, K_SPR, pk(0, 8'h34, 8'h77, 0), "R4");
    bw(2025, 6, 8'h77);

    // R7 idle flush and direct writes
    push(2395, K_BG, pk(8'h80, 8'h81, 3, 8'h44), "R7");
    push(2396, K_BG, pk(8'h80, 8'h3C, 3, 8'h44), "R7");
    bw(2390, 1, 8'h3C);
    wait_cyc(2395);
    rendering = 1'b0;
    push(2410, K_SPR, pk(0, 8'h34, 8'h77, 0), "R7");
    push(2411, K_SPR, pk(0, 8'h34, 8'h77, 8'hAB), "R7");
    bw(2410, 7, 8'hAB);
    push(2718, K_LATE, 0, "R8");
    push(2718, K_BG, pk(8'h80, 8'h3C, 8'h5A, 8'h44), "R7");
    bw(2717, 2, 8'h5A);

    // R1 frame wrap
    push(89341, K_DOT, 340, "R1"); push(89341, K_LINE, 261, "R1");
    push(89342, K_DOT, 0, "R1");   push(89342, K_LINE, 0, "R1");
    wait_cyc(89344);
    @(negedge clk);
    finish_run();
  end
endmodule